// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target with Page Buffer

This block is the serial front end of a small byte-addressed nonvolatile store, sized by parameter from 256 bytes to 2 KB. It watches the two bus lines from a system-clock domain and recognises bus start and stop conditions. It accepts a device-select byte and builds a full byte address from an address byte plus, on the larger sizes, spare select bits. It gathers write data in a one-page buffer. A STOP then commits the buffered bytes to a synchronous RAM, after which a programmable busy period follows.

A host writes one byte or a burst of bytes within a page. It reads from the internal pointer, from an address set by a dummy write followed by a repeated START, or in a run of bytes that walks through the whole array. The target never holds the clock low. It only pulls the data line low through `sda_pull_o`, which an open-drain pad turns into the bus level. Nothing at the edge is a stream, so there is no valid/ready handshake and no back-pressure. The only flow control is the NACK given while the commit is in progress.

Top module: `eeprom_i2c_target`

## Requirements
- R1: The select byte is sent MSB first as bits [7:4]=1010, three middle bits [3:1], and R/W in bit 0 (1 = read). With k = log2(MEM_BYTES)-8 internal bits, middle bits 0..k-1 are taken as address bits 8..(7+k). The remaining middle bits must equal the same-numbered bits of `dev_pins_i`.
- R2: The target pulls SDA low for the ninth clock after a matching select byte, after an address byte and after each write data byte. For a non-matching select byte it leaves SDA released, including on all later bytes, until the next START.
- R3: A STOP after a write command that carried at least one data byte starts the commit, and `busy_o` then stays high for WR_CYCLES system clocks. After that, the written bytes read back.
- R4: While `busy_o` is high, the target NACKs its own select byte and accepts no data. This allows acknowledge polling.
- R5: In a write burst, only the low log2(PAGE_BYTES) pointer bits advance after each data byte. A burst longer than one page wraps to the page start and overwrites the earlier bytes. No byte outside the page changes.
- R6: A START that arrives before the STOP discards every buffered write byte, and no commit follows.
- R7: A read command with no address phase returns the byte at the internal pointer. The pointer sits one past the last byte transferred.
- R8: A dummy write of the address followed by a repeated START and a read command returns the byte at that address.
- R9: In a read, a host ACK makes the target send the next byte. The pointer steps across page boundaries and wraps from the last array byte to address 0. A host NACK ends the read.
- R10: Every array byte reads FFh after power-up.
- R11: The target samples SDA on the SCL rising edge. It changes its own SDA drive only while SCL is low.
- R12: After reset, SDA is released and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_pins_i | input | 3 | Strapped select bits compared with the middle select bits |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | High while a commit is in progress |

## Verification
The bench builds the target with MEM_BYTES=512, so one middle select bit acts as address bit 8 and the other two are compared with the pins. This puts the top-of-array wrap at 0x1FF within reach of a short read. WR_CYCLES=2000 is longer than one select byte on the bench bus, so the first poll after a write must be refused. PAGE_BYTES=16 and a three-sample filter are kept, so an 18-byte burst crosses the page end.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_DEV,
    ST_RX_ADDR,
    ST_RX_DATA,
    ST_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = FILT_LEN / 2;

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] win_q;
  logic                level_q, level_d;

  function automatic int ones(input logic [FILT_LEN-1:0] v);
    int n = 0;
    for (int i = 0; i < FILT_LEN; i++) n += int'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      win_q   <= '1;
      level_q <= 1'b1;
      level_d <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], pin_i};
      win_q   <= {win_q[FILT_LEN-2:0], sync_q[1]};
      level_q <= (ones(win_q) > HALF);
      level_d <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~level_d;
  assign fall_o  = ~level_q & level_d;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // erased contents at power-up: R10
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/eeprom_write_cycle.sv
module eeprom_write_cycle #(
  parameter int ADDR_W    = 8,
  parameter int PG_W      = 4,
  parameter int WR_CYCLES = 625000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   buf_we_i,
  input  logic [PG_W-1:0]        buf_idx_i,
  input  logic [7:0]             buf_data_i,
  input  logic                   buf_clr_i,
  input  logic                   commit_i,
  input  logic [ADDR_W-PG_W-1:0] page_i,
  output logic                   busy_o,
  output logic                   ram_we_o,
  output logic [ADDR_W-1:0]      ram_addr_o,
  output logic [7:0]             ram_data_o
);
  localparam int PG_BYTES = 1 << PG_W;
  localparam int CNT_W    = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

  logic [7:0]             pbuf [PG_BYTES];
  logic [PG_BYTES-1:0]    mask_q;
  logic [ADDR_W-PG_W-1:0] page_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   busy_q;
  logic [PG_W-1:0]        idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        busy_q <= 1'b0;
        mask_q <= '0;
      end
    end else if (commit_i && (|mask_q)) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      page_q <= page_i;
    end else if (buf_clr_i) begin
      mask_q <= '0;
    end else if (buf_we_i) begin
      mask_q[buf_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we_i && !busy_q) pbuf[buf_idx_i] <= buf_data_i;
  end

  // first PG_BYTES cycles of the busy window copy the page into the array
  assign idx        = cnt_q[PG_W-1:0];
  assign ram_we_o   = busy_q && (cnt_q < CNT_W'(PG_BYTES)) && mask_q[idx];
  assign ram_addr_o = {page_q, idx};
  assign ram_data_o = pbuf[idx];
  assign busy_o     = busy_q;

  AST_NO_BUF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !buf_we_i); // R4
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 625000,
  parameter int FILT_LEN   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_pins_i,
  output logic       sda_pull_o,
  output logic       busy_o
);
  import eeprom_pkg::*;

  localparam int ADDR_W  = $clog2(MEM_BYTES);
  localparam int PG_W    = $clog2(PAGE_BYTES);
  localparam int HI_BITS = ADDR_W - 8;

  logic scl_f, scl_rise, scl_fall;
  logic sda_f, sda_rise, sda_fall;
  logic start_evt, stop_evt;

  i2c_pin_filter #(.FILT_LEN(FILT_LEN)) i_scl_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
    .level_o(scl_f), .rise_o(scl_rise), .fall_o(scl_fall));

  i2c_pin_filter #(.FILT_LEN(FILT_LEN)) i_sda_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
    .level_o(sda_f), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start_evt = sda_fall && scl_f;
  assign stop_evt  = sda_rise && scl_f;

  tgt_state_e        state_q, after_ack_q;
  logic [3:0]        bit_cnt_q;
  logic [7:0]        rx_sh_q, tx_sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [2:0]        dev_hi_q;
  logic              pull_q, wr_mode_q, mack_q;
  logic              buf_we_q, buf_clr_q, commit_q;
  logic [PG_W-1:0]   buf_idx_q;
  logic [7:0]        buf_data_q;
  logic [7:0]        ram_q;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [7:0]        ram_wdata;
  logic [ADDR_W-1:0] addr_load;
  logic              dev_ok;

  // spare select bits extend the byte address on larger arrays: R1
  generate
    if (HI_BITS == 0) begin : g_no_hi
      assign addr_load = rx_sh_q;
    end else begin : g_hi
      assign addr_load = {dev_hi_q[HI_BITS-1:0], rx_sh_q};
    end
  endgenerate

  always_comb begin
    dev_ok = (rx_sh_q[7:4] == DEV_TYPE);
    for (int i = 0; i < 3; i++) begin
      if (i >= HI_BITS && rx_sh_q[i+1] != dev_pins_i[i]) dev_ok = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      after_ack_q <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      ptr_q       <= '0;
      dev_hi_q    <= '0;
      pull_q      <= 1'b0;
      wr_mode_q   <= 1'b0;
      mack_q      <= 1'b0;
      buf_we_q    <= 1'b0;
      buf_clr_q   <= 1'b0;
      commit_q    <= 1'b0;
      buf_idx_q   <= '0;
      buf_data_q  <= '0;
    end else begin
      buf_we_q  <= 1'b0;
      buf_clr_q <= 1'b0;
      commit_q  <= 1'b0;
      if (start_evt) begin
        state_q   <= ST_RX_DEV;
        bit_cnt_q <= '0;
        pull_q    <= 1'b0;
        wr_mode_q <= 1'b0;
        buf_clr_q <= !busy_o;
      end else if (stop_evt) begin
        state_q   <= ST_IDLE;
        pull_q    <= 1'b0;
        commit_q  <= wr_mode_q;
        wr_mode_q <= 1'b0;
      end else if (scl_rise) begin
        case (state_q)
          ST_RX_DEV, ST_RX_ADDR, ST_RX_DATA: begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
          ST_TX:     bit_cnt_q <= bit_cnt_q + 1'b1;
          ST_TX_ACK: mack_q    <= !sda_f;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state_q)
          ST_RX_DEV: if (bit_cnt_q == 4'd8) begin
            if (dev_ok && !busy_o) begin
              pull_q      <= 1'b1;
              state_q     <= ST_ACK;
              dev_hi_q    <= rx_sh_q[3:1];
              after_ack_q <= rx_sh_q[0] ? ST_TX : ST_RX_ADDR;
              wr_mode_q   <= !rx_sh_q[0];
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_RX_ADDR: if (bit_cnt_q == 4'd8) begin
            ptr_q       <= addr_load;
            pull_q      <= 1'b1;
            state_q     <= ST_ACK;
            after_ack_q <= ST_RX_DATA;
          end
          ST_RX_DATA: if (bit_cnt_q == 4'd8) begin
            buf_we_q          <= 1'b1;
            buf_idx_q         <= ptr_q[PG_W-1:0];
            buf_data_q        <= rx_sh_q;
            ptr_q[PG_W-1:0]   <= ptr_q[PG_W-1:0] + PG_W'(1);
            pull_q            <= 1'b1;
            state_q           <= ST_ACK;
            after_ack_q       <= ST_RX_DATA;
          end
          ST_ACK: begin
            bit_cnt_q <= '0;
            state_q   <= after_ack_q;
            if (after_ack_q == ST_TX) begin
              tx_sh_q <= ram_q;
              pull_q  <= !ram_q[7];
            end else begin
              pull_q  <= 1'b0;
            end
          end
          ST_TX: if (bit_cnt_q == 4'd8) begin
            pull_q  <= 1'b0;
            state_q <= ST_TX_ACK;
            ptr_q   <= ptr_q + 1'b1;
          end else begin
            pull_q  <= !tx_sh_q[6];
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
          end
          ST_TX_ACK: if (mack_q) begin
            tx_sh_q   <= ram_q;
            pull_q    <= !ram_q[7];
            bit_cnt_q <= '0;
            state_q   <= ST_TX;
          end else begin
            state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  eeprom_write_cycle #(.ADDR_W(ADDR_W), .PG_W(PG_W), .WR_CYCLES(WR_CYCLES)) i_wcyc (
    .clk(clk), .rst_n(rst_n),
    .buf_we_i(buf_we_q), .buf_idx_i(buf_idx_q), .buf_data_i(buf_data_q),
    .buf_clr_i(buf_clr_q), .commit_i(commit_q), .page_i(ptr_q[ADDR_W-1:PG_W]),
    .busy_o(busy_o), .ram_we_o(ram_we), .ram_addr_o(ram_waddr), .ram_data_o(ram_wdata));

  eeprom_array #(.ADDR_W(ADDR_W)) i_array (
    .clk(clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
    .raddr_i(ptr_q), .rdata_o(ram_q));

  assign sda_pull_o = pull_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q); // R2
  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !scl_f); // R11
  AST_BUSY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pull_q); // R4
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_q |-> (ptr_q[ADDR_W-1:PG_W] == $past(ptr_q[ADDR_W-1:PG_W]))); // R5
endmodule

// File: tb/test_eeprom_i2c_target.sv
module test_eeprom_i2c_target;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic dut_low, busy;
  logic sda_line;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = !(m_low || dut_low);

  eeprom_i2c_target #(.MEM_BYTES(512), .PAGE_BYTES(16), .WR_CYCLES(2000), .FILT_LEN(3)) i_eeprom_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .dev_pins_i(3'b101), .sda_pull_o(dut_low), .busy_o(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic a8, input logic rd);
    return {4'b1010, 1'b1, 1'b0, a8, rd};
  endfunction

  task automatic i2c_start();
    m_low = 1'b0; wq(1); scl = 1'b1; wq(1); m_low = 1'b1; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; wq(1); scl = 1'b1; wq(1); m_low = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1);
    end
    m_low = 1'b0; wq(1); scl = 1'b1; wq(1); ack = !sda_line; wq(1); scl = 1'b0; wq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq(1); scl = 1'b1; wq(1); b = {b[6:0], sda_line}; wq(1); scl = 1'b0;
    end
    wq(1); m_low = give_ack; wq(1); scl = 1'b1; wq(2); scl = 1'b0; wq(1); m_low = 1'b0;
  endtask

  task automatic wait_ready(output int polls);
    bit ack;
    polls = 0;
    for (int i = 0; i < 40; i++) begin
      i2c_start(); send_byte(dev(1'b0, 1'b0), ack); i2c_stop(); polls++;
      if (ack) break;
    end
  endtask

  task automatic mem_write(input logic [8:0] a, input logic [7:0] d);
    bit ack; int polls;
    i2c_start(); send_byte(dev(a[8], 1'b0), ack); send_byte(a[7:0], ack); send_byte(d, ack);
    i2c_stop(); wait_ready(polls);
  endtask

  task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
    bit ack;
    i2c_start(); send_byte(dev(a[8], 1'b0), ack); send_byte(a[7:0], ack);
    i2c_start(); send_byte(dev(a[8], 1'b1), ack); recv_byte(1'b0, d); i2c_stop();
  endtask

  task automatic t_reset();
    chk(dut_low == 1'b0, "R12 sda released", dut_low, 0);
    chk(busy == 1'b0, "R12 busy low", busy, 0);
  endtask

  task automatic t_blank();
    logic [7:0] d;
    rand_read(9'h010, d);
    chk(d == 8'hFF, "R10 erased byte via R8 random read", d, 8'hFF);
  endtask

  task automatic t_byte_write();
    bit a0, a1, a2, ap; int polls; logic [7:0] d;
    i2c_start(); send_byte(dev(1'b0, 1'b0), a0); send_byte(8'h05, a1); send_byte(8'hA5, a2);
    i2c_stop();
    chk(a0 && a1 && a2, "R2 acks on select/address/data", {a0, a1, a2}, 3'b111);
    chk(busy == 1'b1, "R3 busy after STOP", busy, 1);
    i2c_start(); send_byte(dev(1'b0, 1'b0), ap); i2c_stop();
    chk(!ap, "R4 select NACKed while busy", ap, 0);
    wait_ready(polls);
    chk(polls >= 1 && polls < 40, "R4 polling ends with ACK", polls, 1);
    chk(busy == 1'b0, "R3 busy ends", busy, 0);
    rand_read(9'h005, d);
    chk(d == 8'hA5, "R3 byte written", d, 8'hA5);
  endtask

  task automatic t_page();
    bit ack; int nack_cnt = 0; int polls; logic [7:0] d; logic [7:0] exp;
    i2c_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h1E, ack);
    for (int i = 0; i < 18; i++) begin
      send_byte(8'h40 + 8'(i), ack);
      if (!ack) nack_cnt++;
    end
    i2c_stop(); wait_ready(polls);
    chk(nack_cnt == 0, "R2 every page byte acked", nack_cnt, 0);
    i2c_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h10, ack);
    i2c_start(); send_byte(dev(1'b0, 1'b1), ack);
    for (int k = 0; k < 17; k++) begin
      recv_byte(k != 16, d);
      if (k < 14) exp = 8'h42 + 8'(k);
      else if (k == 14) exp = 8'h50;
      else if (k == 15) exp = 8'h51;
      else exp = 8'hFF;
      chk(d == exp, (k == 16) ? "R5 next page untouched (R9 run)" : "R5 page wrap content", d, exp);
    end
    i2c_stop();
  endtask

  task automatic t_current();
    bit ack; logic [7:0] d;
    rand_read(9'h01E, d);
    chk(d == 8'h50, "R8 random read", d, 8'h50);
    i2c_start(); send_byte(dev(1'b0, 1'b1), ack); recv_byte(1'b0, d); i2c_stop();
    chk(d == 8'h51, "R7 current address read", d, 8'h51);
  endtask

  task automatic t_upper();
    logic [7:0] d;
    mem_write(9'h105, 8'h3C);
    rand_read(9'h105, d);
    chk(d == 8'h3C, "R1 select bit as address bit 8", d, 8'h3C);
    rand_read(9'h005, d);
    chk(d == 8'hA5, "R1 low half unaffected", d, 8'hA5);
  endtask

  task automatic t_mismatch();
    bit a0, a1, a2; logic [7:0] d;
    i2c_start(); send_byte({4'b1010, 1'b0, 1'b0, 1'b0, 1'b0}, a0);
    send_byte(8'h05, a1); send_byte(8'hEE, a2); i2c_stop();
    chk(!a0, "R1 pin mismatch NACK", a0, 0);
    chk(!a1 && !a2, "R2 stays released after mismatch", {a1, a2}, 0);
    wq(2);
    chk(busy == 1'b0, "R2 no commit after mismatch", busy, 0);
    rand_read(9'h005, d);
    chk(d == 8'hA5, "R2 memory untouched", d, 8'hA5);
  endtask

  task automatic t_wrap();
    bit ack; logic [7:0] d0, d1;
    mem_write(9'h1FF, 8'h77);
    mem_write(9'h000, 8'h88);
    i2c_start(); send_byte(dev(1'b1, 1'b0), ack); send_byte(8'hFF, ack);
    i2c_start(); send_byte(dev(1'b1, 1'b1), ack);
    recv_byte(1'b1, d0); recv_byte(1'b0, d1); i2c_stop();
    chk(d0 == 8'h77, "R9 last array byte", d0, 8'h77);
    chk(d1 == 8'h88, "R9 wrap to address 0", d1, 8'h88);
  endtask

  task automatic t_abort();
    bit ack; logic [7:0] d;
    i2c_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h30, ack); send_byte(8'h99, ack);
    i2c_start(); i2c_stop();
    wq(2);
    chk(busy == 1'b0, "R6 no commit after START abort", busy, 0);
    rand_read(9'h030, d);
    chk(d == 8'hFF, "R6 aborted byte not stored", d, 8'hFF);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_blank();
    t_byte_write();
    t_page();
    t_current();
    t_upper();
    t_mismatch();
    t_wrap();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule